// File: doc/BRIEF.md
# Floppy Data-Poll Wait-State Generator

This block drives the host bus READY line for a floppy disk controller card whose software moves sector bytes one at a time by polling the controller's data register. If the host reads or writes the data register before the controller has a byte, READY drops. The CPU then sits in wait states instead of running a software polling loop. The stall ends as soon as the controller raises its data request, or as soon as it signals the end of the command.

The block also holds the shared motor-on timer. It is a retriggerable one-shot, started by the rising edge of a host-controlled strobe bit, and it keeps every drive motor spinning for a fixed number of clock cycles after the last trigger. The same motor-on level goes to three places: it forces the controller's ready input, the host can read it back, and it gates the stall. With a stopped motor a data poll can therefore never hang the bus.

A parameter chooses between two decode forms. The basic form matches the low three address bits against the data-register pattern. The revised form checks that the address is even and combines a separately formed trap term.

Top module: `ready_trap_gen`

## Requirements
- R1: `ready` is low only while all of these hold: `ctrlSel` is 1, `addrLow[2:0]` equals 3'b110, `trapEn` is 1, `fdcDrq` is 0, `fdcIntrq` is 0 and `motorOn` is 1. Address bits above bit 2 have no effect.
- R2: If any one of the conditions in R1 is false, `ready` is 1 in the same cycle.
- R3: `ready` is a combinational function of the present inputs and of `motorOn`. When `fdcIntrq` or `fdcDrq` rises during a stall, `ready` returns to 1 before the next clock edge.
- R4: A rising edge of `motorStrobe` that is sampled at a clock edge sets `motorOn` after that edge. `motorOn` then stays 1 for exactly MOTOR_CYCLES clock cycles, provided no further rising edge arrives.
- R5: Each new rising edge of `motorStrobe` restarts the full MOTOR_CYCLES count. Holding `motorStrobe` high does not retrigger the timer.
- R6: `fdcForceReady` and `motorSense` always equal `motorOn`.
- R7: While `rst_n` is 0, and after its release until the first trigger, `motorOn` is 0 and `ready` is 1.
- R8: With VARIANT=1, the stall condition is built as: an even address, no DRQ, no INTRQ, `ctrlSel` high, and a trap term formed from `trapEn`, address bits [2:1] both set, and `motorOn`. This gives the same port behaviour as R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrlSel | input | 1 | Decoded flag: the current access targets the controller window |
| addrLow | input | ADDR_W | Low address bits of the current access |
| trapEn | input | 1 | Host bit enabling wait-state generation |
| fdcDrq | input | 1 | Controller data request (byte available) |
| fdcIntrq | input | 1 | Controller interrupt request (command ended) |
| motorStrobe | input | 1 | Host bit; its rising edge triggers the motor timer |
| ready | output | 1 | Bus READY; 0 inserts wait states |
| motorOn | output | 1 | Motor enable for all drives |
| fdcForceReady | output | 1 | Forces the controller's ready input while the motor runs |
| motorSense | output | 1 | Motor status read back by the host |

## Verification
The assertions assume that `fdcDrq`, `fdcIntrq`, `ctrlSel`, `trapEn` and `addrLow` are steady in the time between edges, so that the combinational READY they observe is the value the bus sees. They also assume `motorStrobe` changes at most once per cycle. The stimulus drives every input once per cycle, just after the falling edge. `fdcDrq` and `fdcIntrq` are biased low and `ctrlSel`/`trapEn` are biased high, so stalls actually happen. Strobe edges are kept sparse, so the timer both expires and is retriggered while still running.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef struct packed {
    logic restart;
  } rtg_strobe_t;
endpackage

// File: rtl/rtg_motor_dp.sv
module rtg_motor_dp
  import rtg_pkg::*;
#(
  parameter int MOTOR_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  rtg_strobe_t ctl,
  output logic        motorOn
);
  localparam int CNT_W = $clog2(MOTOR_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)
      remain <= '0;
    else if (ctl.restart)
      remain <= CNT_W'(MOTOR_CYCLES);
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign motorOn = (remain != '0);

  // R4: a trigger loads the full period
  a_r4_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.restart |=> remain == CNT_W'(MOTOR_CYCLES));

  // R4: without a trigger a running timer counts down by one
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (motorOn && !ctl.restart) |=> remain == $past(remain) - 1'b1);
endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              motorStrobe,
  input  logic              ctrlSel,
  input  logic [ADDR_W-1:0] addrLow,
  input  logic              trapEn,
  input  logic              fdcDrq,
  input  logic              fdcIntrq,
  input  logic              motorOn,
  output rtg_strobe_t       ctl,
  output logic              ready
);
  logic strobeLast;
  logic stall;
  logic idleCtl;

  always_ff @(posedge clk) begin
    if (!rst_n) strobeLast <= 1'b0;
    else        strobeLast <= motorStrobe;
  end

  assign ctl.restart = motorStrobe && !strobeLast;
  assign idleCtl     = !fdcDrq && !fdcIntrq;

  generate
    if (VARIANT == 0) begin : g_basic
      assign stall = ctrlSel && (addrLow[2:0] == 3'b110) && trapEn &&
                     idleCtl && motorOn;
    end else begin : g_revised
      logic trapTerm;
      logic evenAddr;
      assign trapTerm = trapEn && (addrLow[2:1] == 2'b11) && motorOn;
      assign evenAddr = !addrLow[0];
      assign stall    = ctrlSel && evenAddr && idleCtl && trapTerm;
    end
  endgenerate

  assign ready = !stall;

  // R2: a stopped motor never holds the bus
  a_r2_motor_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !motorOn |-> ready);

  // R3: a finished command releases the bus in the same cycle
  a_r3_intrq_release: assert property (@(posedge clk) disable iff (!rst_n)
    fdcIntrq |-> ready);

  // R3: an available byte releases the bus in the same cycle
  a_r3_drq_release: assert property (@(posedge clk) disable iff (!rst_n)
    fdcDrq |-> ready);

  // R5: a strobe held high does not restart the timer
  a_r5_level_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (motorStrobe && $past(motorStrobe)) |-> !ctl.restart);
endmodule

// File: rtl/ready_trap_gen.sv
module ready_trap_gen
  import rtg_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int VARIANT      = 0,
  parameter int MOTOR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlSel,
  input  logic [ADDR_W-1:0] addrLow,
  input  logic              trapEn,
  input  logic              fdcDrq,
  input  logic              fdcIntrq,
  input  logic              motorStrobe,
  output logic              ready,
  output logic              motorOn,
  output logic              fdcForceReady,
  output logic              motorSense
);
  rtg_strobe_t ctl;

  rtg_ctrl #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) uCtrl (
    .clk(clk), .rst_n(rst_n), .motorStrobe(motorStrobe), .ctrlSel(ctrlSel),
    .addrLow(addrLow), .trapEn(trapEn), .fdcDrq(fdcDrq), .fdcIntrq(fdcIntrq),
    .motorOn(motorOn), .ctl(ctl), .ready(ready)
  );

  rtg_motor_dp #(.MOTOR_CYCLES(MOTOR_CYCLES)) uMotor (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .motorOn(motorOn)
  );

  assign fdcForceReady = motorOn;
  assign motorSense    = motorOn;

  // R7: the motor is off in the first cycle after reset
  a_r7_reset_off: assert property (@(posedge clk)
    !rst_n |=> !motorOn);
endmodule

// File: tb/sim_ready_trap_gen.sv
`timescale 1ns/1ps
module sim_ready_trap_gen;
  localparam int AW = 4;
  localparam int NCYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrlSel = 1'b0, trapEn = 1'b0, fdcDrq = 1'b0, fdcIntrq = 1'b0, motorStrobe = 1'b0;
  logic [AW-1:0] addrLow = '0;
  logic ready, motorOn, fdcForceReady, motorSense;
  logic ready1, motorOn1, fdcForceReady1, motorSense1;

  int checks = 0, errors = 0;
  int expLeft = 0;
  logic prevStrobe = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ready_trap_gen #(.ADDR_W(AW), .VARIANT(0), .MOTOR_CYCLES(NCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrlSel(ctrlSel), .addrLow(addrLow), .trapEn(trapEn),
    .fdcDrq(fdcDrq), .fdcIntrq(fdcIntrq), .motorStrobe(motorStrobe),
    .ready(ready), .motorOn(motorOn), .fdcForceReady(fdcForceReady), .motorSense(motorSense));

  ready_trap_gen #(.ADDR_W(AW), .VARIANT(1), .MOTOR_CYCLES(NCYC)) u1 (
    .clk(clk), .rst_n(rst_n), .ctrlSel(ctrlSel), .addrLow(addrLow), .trapEn(trapEn),
    .fdcDrq(fdcDrq), .fdcIntrq(fdcIntrq), .motorStrobe(motorStrobe),
    .ready(ready1), .motorOn(motorOn1), .fdcForceReady(fdcForceReady1), .motorSense(motorSense1));

  function automatic logic expReady(input logic mot);
    return !(ctrlSel && addrLow[2:0] == 3'b110 && trapEn && !fdcDrq && !fdcIntrq && mot);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    logic m;
    m = (expLeft != 0);
    chk({req, " ready"}, ready, expReady(m));
    chk({req, " R8 ready"}, ready1, expReady(m));
    chk({req, " R4 motorOn"}, motorOn, m);
    chk({req, " R8 motorOn"}, motorOn1, m);
    chk("R6 force", fdcForceReady, m);
    chk("R6 sense", motorSense, m);
  endtask

  // model update at each clock edge
  always @(posedge clk) begin
    if (!rst_n) expLeft <= 0;
    else if (motorStrobe && !prevStrobe) expLeft <= NCYC;
    else if (expLeft != 0) expLeft <= expLeft - 1;
    prevStrobe <= rst_n ? motorStrobe : 1'b0;
  end

  task automatic drive(input logic s, input logic t, input logic [AW-1:0] a,
                       input logic d, input logic i, input logic st);
    @(negedge clk);
    ctrlSel = s; trapEn = t; addrLow = a; fdcDrq = d; fdcIntrq = i; motorStrobe = st;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R7: reset state, trap conditions otherwise met
    drive(1, 1, 4'h6, 0, 0, 0);
    chk("R7 ready in reset", ready, 1'b1);
    chk("R7 motor in reset", motorOn, 1'b0);
    @(negedge clk); rst_n = 1'b1; #1;
    checkAll("R7");
    // R4: trigger and measure exact on-time
    drive(1, 1, 4'h6, 0, 0, 1);
    chk("R4 not yet on", motorOn, 1'b0);
    for (int k = 0; k < NCYC; k++) begin
      drive(1, 1, 4'h6, 0, 0, 1);
      chk("R4 on window", motorOn, 1'b1);
      chk("R1 stall", ready, 1'b0);
      chk("R8 stall", ready1, 1'b0);
    end
    drive(1, 1, 4'h6, 0, 0, 1);
    chk("R4 expired / R5 held level", motorOn, 1'b0);
    chk("R2 motor off ready", ready, 1'b1);
    // R5: retrigger mid-count
    drive(1, 1, 4'hE, 0, 0, 0);
    drive(1, 1, 4'hE, 0, 0, 1);
    for (int k = 0; k < NCYC/2; k++) drive(1, 1, 4'hE, 0, 0, 0);
    drive(1, 1, 4'hE, 0, 0, 1);
    for (int k = 0; k < NCYC; k++) begin
      drive(1, 1, 4'hE, 0, 0, 0);
      chk("R5 full restart", motorOn, 1'b1);
      chk("R1 upper bits ignored", ready, 1'b0);
    end
    drive(1, 1, 4'hE, 0, 0, 0);
    chk("R5 end after restart", motorOn, 1'b0);
    // R3: release within cycle
    drive(1, 1, 4'h6, 0, 0, 1);
    drive(1, 1, 4'h6, 0, 0, 1);
    chk("R1 stall again", ready, 1'b0);
    fdcIntrq = 1'b1; #1;
    chk("R3 intrq release", ready, 1'b1);
    fdcIntrq = 1'b0; #1;
    chk("R3 restall", ready, 1'b0);
    fdcDrq = 1'b1; #1;
    chk("R3 drq release", ready, 1'b1);
    // R2: each condition off
    drive(0, 1, 4'h6, 0, 0, 1); chk("R2 sel low", ready, 1'b1);
    drive(1, 0, 4'h6, 0, 0, 1); chk("R2 trap off", ready, 1'b1);
    drive(1, 1, 4'h7, 0, 0, 1); chk("R2 odd addr", ready, 1'b1);
    drive(1, 1, 4'h4, 0, 0, 1); chk("R2 addr 4", ready, 1'b1);
    drive(1, 1, 4'h2, 0, 0, 1); chk("R8 addr 2", ready1, 1'b1);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom % 8) != 0, ($urandom % 8) != 0, AW'($urandom),
            ($urandom % 4) == 0, ($urandom % 6) == 0,
            (($urandom % 40) == 0) ? ~motorStrobe : motorStrobe);
      checkAll("R1 R2 random");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule